// File: doc/BRIEF.md
# Gated and Compare Interval Timer

This block is a 16-bit up-counting timer for a microcontroller-class subsystem. Software programs a control word, a start count and a reload (compare) value through a small write port. It then sets the enable bit. The timer advances on a prescaled system clock. On every pass through the reload value it raises a one-cycle interrupt, restarts at 0x0001 and toggles its output pin.

There are two counting modes. In compare mode every prescaled clock advances the count, and the input pin is ignored. The delay to the first interrupt is (reload − start + 1) prescaled periods. In gated mode the count advances only while the synchronized input pin sits at the level chosen by a polarity bit. When the pin falls from its active level to its inactive level, an interrupt is also raised. This lets software measure the length of an external pulse.

All three registers can be read back through a combinational read port. The output pin can be preset to a known level by writing the control word with the enable bit cleared.

Top module: `gate_cmp_timer`

## Requirements
- R1: After reset the control word, count and reload registers read 0, `timerOut` is 0 and `irq` is 0.
- R2: In compare mode with a prescale of 1, writing enable at clock edge E0 with start S and reload R (S ≤ R) makes `irq` first rise right after edge E0+(R−S+1).
- R3: Control bits [4:2] select the prescale 2^P (P = 0..7). One count step takes 2^P clocks, so the first interrupt follows (R−S+1)·2^P edges after the enable write. The prescaler restarts from zero whenever the timer is disabled.
- R4: When a count step finds the count equal to the reload value, the count becomes 0x0001, `timerOut` toggles and `irq` pulses. Otherwise `timerOut` only changes on a control write.
- R5: While control bit 0 (enable) is 0, the count and `timerOut` hold their values.
- R6: A control write with bit 0 cleared sets `timerOut` to control bit 6 (initial level) on the next edge. A control write with bit 0 set does not force the output.
- R7: Control bit 1 selects gated mode (1) or compare mode (0). In gated mode the count advances only while the input, after two synchronizing flops, equals control bit 5 (1 = active high, 0 = active low). In compare mode the input has no effect.
- R8: In gated mode with enable set, a change of the synchronized input from active to inactive produces exactly one `irq` pulse, even when no reload takes place.
- R9: When a reload and a gate fall land in the same cycle, only one `irq` pulse is produced. The reload (count 0x0001, output toggle) still takes place.
- R10: `irq` is high for one cycle per event.
- R11: Register addresses are 0 for control (bits 6:0), 1 for count and 2 for reload. Written values read back unchanged on `rdData` for the address on `rdAddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Read data for `rdAddr` |
| timerIn | input | 1 | Asynchronous gate input pin |
| timerOut | output | 1 | Timer output pin, toggled on each reload |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
In gated mode, a reload on reaching the reload value and the falling edge of the gate can fall in the same cycle. The design flags the fall in the last cycle that still counts, so the two events can coincide. The bench provokes this by loading the count equal to the reload value and then pulsing the gate active for a single clock. That one counted step is both the reload and the fall. The result is judged at the pins: exactly one `irq` pulse in the observation window, the count reads 0x0001 and `timerOut` has toggled.

// File: rtl/gct_pkg.sv
package gct_pkg;

  // Control word field positions
  localparam int CTL_EN     = 0;
  localparam int CTL_MODE   = 1;
  localparam int CTL_PS_LSB = 2;
  localparam int CTL_PS_W   = 3;
  localparam int CTL_POL    = 5;
  localparam int CTL_INIT   = 6;
  localparam int CTL_W      = 7;

  // Register addresses
  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_CNT = 2'd1;
  localparam logic [1:0] ADDR_RLD = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;      // one count step this cycle
    logic gateFall;  // gate left its active level (gated mode only)
  } gctStrobe_t;

endpackage

// File: rtl/gct_ctrl.sv
module gct_ctrl
  import gct_pkg::*;
#(
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            gatedMode,
  input  logic [PS_W-1:0] psSel,
  input  logic            gatePol,
  input  logic            timerIn,
  output gctStrobe_t      strobe
);

  localparam int DIV_MAX_W = (1 << PS_W) - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   gateActive;
  logic                   gateQual;
  logic                   advance;
  logic [DIV_MAX_W-1:0]   psCnt;
  logic [DIV_MAX_W-1:0]   divLimit;

  // Input synchronizer
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= timerIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], timerIn};
      end
    end
  endgenerate

  assign gateActive = (syncChain[SYNC_STAGES-1] == gatePol);

  // Counting qualifier lags the level one cycle so the last counted
  // cycle is the cycle in which the fall is flagged.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateQual <= 1'b0;
    else       gateQual <= gateActive;
  end

  assign advance  = enable && (!gatedMode || gateQual);
  assign divLimit = DIV_MAX_W'((32'd1 << psSel) - 32'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 psCnt <= '0;
    else if (!enable)          psCnt <= '0;
    else if (advance) begin
      if (psCnt == divLimit)   psCnt <= '0;
      else                     psCnt <= psCnt + 1'b1;
    end
  end

  assign strobe.tick     = advance && (psCnt == divLimit);
  assign strobe.gateFall = enable && gatedMode && gateQual && !gateActive;

  // R5: a disabled timer leaves its prescaler at zero
  assert_ps_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (psCnt == '0));

  // R7: gated and idle means the prescaler does not move
  assert_gate_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && gatedMode && !gateQual) |=> $stable(psCnt));

endmodule

// File: rtl/gct_datapath.sv
module gct_datapath
  import gct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  gctStrobe_t       strobe,
  output logic [CTL_W-1:0] ctlReg,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] reloadVal,
  output logic             timerOut,
  output logic             irq
);

  localparam logic [CNT_W-1:0] RESTART = CNT_W'(1);

  logic ctlWrite, cntWrite, rldWrite;
  logic hit, reloadEv;

  assign ctlWrite = wrEn && (wrAddr == ADDR_CTL);
  assign cntWrite = wrEn && (wrAddr == ADDR_CNT);
  assign rldWrite = wrEn && (wrAddr == ADDR_RLD);

  assign hit      = (countVal == reloadVal);
  assign reloadEv = strobe.tick && hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ctlReg <= '0;
    else if (ctlWrite) ctlReg <= wrData[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         reloadVal <= '0;
    else if (rldWrite) reloadVal <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              countVal <= '0;
    else if (cntWrite)      countVal <= wrData;
    else if (reloadEv)      countVal <= RESTART;
    else if (strobe.tick)   countVal <= countVal + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             timerOut <= 1'b0;
    else if (ctlWrite && !wrData[CTL_EN])  timerOut <= wrData[CTL_INIT];
    else if (reloadEv)                     timerOut <= !timerOut;
  end

  // One pulse even when both causes land together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= reloadEv || strobe.gateFall;
  end

  assert_restart_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && hit && !cntWrite) |=> (countVal == RESTART));

  assert_out_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlWrite && !(strobe.tick && hit)) |=> $stable(timerOut));

  assert_init_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && !wrData[CTL_EN]) |=> (timerOut == $past(wrData[CTL_INIT])));

  assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlReg[CTL_EN] && !cntWrite) |=> $stable(countVal));

endmodule

// File: rtl/gate_cmp_timer.sv
module gate_cmp_timer
  import gct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  input  logic             timerIn,
  output logic             timerOut,
  output logic             irq
);

  gctStrobe_t       strobe;
  logic [CTL_W-1:0] ctlReg;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] reloadVal;

  gct_ctrl #(
    .PS_W        (CTL_PS_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (ctlReg[CTL_EN]),
    .gatedMode (ctlReg[CTL_MODE]),
    .psSel     (ctlReg[CTL_PS_LSB +: CTL_PS_W]),
    .gatePol   (ctlReg[CTL_POL]),
    .timerIn   (timerIn),
    .strobe    (strobe)
  );

  gct_datapath #(
    .CNT_W (CNT_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .ctlReg    (ctlReg),
    .countVal  (countVal),
    .reloadVal (reloadVal),
    .timerOut  (timerOut),
    .irq       (irq)
  );

  always_comb begin
    case (rdAddr)
      ADDR_CTL: rdData = CNT_W'(ctlReg);
      ADDR_CNT: rdData = countVal;
      ADDR_RLD: rdData = reloadVal;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: tb/test_gate_cmp_timer.sv
module test_gate_cmp_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [1:0]  rdAddr = 2'd0;
  logic [15:0] rdData;
  logic        timerIn = 1'b0;
  logic        timerOut;
  logic        irq;

  int total = 0;
  int fails = 0;

  always #2 clk = !clk;

  gate_cmp_timer i_gate_cmp_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .timerIn(timerIn),
    .timerOut(timerOut), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic edgesToIrq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 2000);
  endtask

  task automatic countIrqs(input int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
  endtask

  task automatic testReset();
    logic [15:0] v;
    readReg(2'd0, v); check("R1 ctl", v, 0);
    readReg(2'd1, v); check("R1 count", v, 0);
    readReg(2'd2, v); check("R1 reload", v, 0);
    check("R1 out", timerOut, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic testReadback();
    logic [15:0] v;
    writeReg(2'd1, 16'h1234);
    writeReg(2'd2, 16'hABCD);
    writeReg(2'd0, 16'h0040);
    readReg(2'd1, v); check("R11 count", v, 16'h1234);
    readReg(2'd2, v); check("R11 reload", v, 16'hABCD);
    readReg(2'd0, v); check("R11 ctl", v, 16'h0040);
    check("R6 init high", timerOut, 1);
  endtask

  task automatic testCompareBasic();
    int n;
    logic [15:0] v;
    writeReg(2'd0, 16'h0000);
    check("R6 init low", timerOut, 0);
    writeReg(2'd1, 16'd5);
    writeReg(2'd2, 16'd8);
    timerIn = 1'b1;
    writeReg(2'd0, 16'h0001);
    timerIn = 1'b0;
    edgesToIrq(n);
    check("R2 interval", n, 4);
    readReg(2'd1, v); check("R4 restart", v, 1);
    check("R4 toggle", timerOut, 1);
    @(negedge clk);
    check("R10 pulse width", irq, 0);
  endtask

  task automatic testPrescale();
    int n;
    writeReg(2'd0, 16'h0000);
    writeReg(2'd1, 16'd10);
    writeReg(2'd2, 16'd12);
    writeReg(2'd0, 16'h0009);
    edgesToIrq(n);
    check("R3 div4", n, 12);
    writeReg(2'd0, 16'h0000);
    writeReg(2'd1, 16'd300);
    writeReg(2'd2, 16'd300);
    writeReg(2'd0, 16'h001D);
    edgesToIrq(n);
    check("R3 div128", n, 128);
  endtask

  task automatic testDisableHold();
    logic [15:0] c;
    logic [15:0] v;
    writeReg(2'd0, 16'h0000);
    writeReg(2'd1, 16'd100);
    writeReg(2'd2, 16'hFFFF);
    writeReg(2'd0, 16'h0009);
    repeat (10) @(negedge clk);
    writeReg(2'd0, 16'h0048);
    check("R6 forced high", timerOut, 1);
    readReg(2'd1, c);
    repeat (20) @(negedge clk);
    readReg(2'd1, v); check("R5 count held", v, c);
    check("R5 out held", timerOut, 1);
    writeReg(2'd0, 16'h0009);
    check("R6 enable keeps out", timerOut, 1);
    repeat (3) @(negedge clk);
    readReg(2'd1, v); check("R3 prescaler cleared", v, c);
    @(negedge clk);
    readReg(2'd1, v); check("R3 first step", v, c + 16'd1);
  endtask

  task automatic testGated(input logic pol);
    logic [15:0] v;
    int p;
    logic [15:0] ctlOff;
    logic [15:0] ctlOn;
    ctlOff = pol ? 16'h0022 : 16'h0002;
    ctlOn  = ctlOff | 16'h0001;
    timerIn = !pol;
    writeReg(2'd0, ctlOff);
    repeat (5) @(negedge clk);
    writeReg(2'd1, 16'd0);
    writeReg(2'd2, 16'hFFFF);
    writeReg(2'd0, ctlOn);
    repeat (20) @(negedge clk);
    readReg(2'd1, v); check("R7 idle gate", v, 0);
    timerIn = pol;
    repeat (7) @(negedge clk);
    timerIn = !pol;
    countIrqs(10, p);
    readReg(2'd1, v); check("R7 gated steps", v, 7);
    check("R8 fall irq", p, 1);
  endtask

  task automatic testCoincide();
    logic [15:0] v;
    logic o;
    int p;
    timerIn = 1'b0;
    writeReg(2'd0, 16'h0022);
    repeat (5) @(negedge clk);
    writeReg(2'd1, 16'd50);
    writeReg(2'd2, 16'd50);
    writeReg(2'd0, 16'h0023);
    o = timerOut;
    repeat (3) @(negedge clk);
    readReg(2'd1, v); check("R7 no step before gate", v, 50);
    timerIn = 1'b1;
    @(negedge clk);
    timerIn = 1'b0;
    countIrqs(10, p);
    check("R9 single pulse", p, 1);
    readReg(2'd1, v); check("R9 restart", v, 1);
    check("R9 toggle", timerOut, !o);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testCompareBasic();
    testPrescale();
    testDisableHold();
    testGated(1'b1);
    testGated(1'b0);
    testCoincide();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #400000;
    total++;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule